// File: doc/BRIEF.md
# CAN Controller Control and Interrupt Register

This block is the CPU-facing control byte of a small CAN controller, together with the interrupt logic that it gates. The CPU writes and reads the byte at one decoded 8-bit offset. The protocol engine drives single-cycle event strobes into the block. The block returns one interrupt request line and the control bits that the rest of the core needs.

Setting the reset-request bit freezes the rest of the configuration. While that bit is 1, a CPU write can only change the reset-request bit itself. The protocol core has one way to modify the register: a strobe that forces reset-request to 1. Each of the four interrupt enables selects its own group of events. An enabled event sets a pending flag, and the flag stays set until the CPU acknowledges it.

The speed bit also selects which bus-line transitions are reported to the bit-timing logic as resynchronization edges.

Top module: `can_ctrl_reg`

## Requirements
- R1: After reset, the register reads 0x01 (reset-request set, all other bits 0), `irq` is 0, `buf_unmap` is 0 and `resync_edge` is 0.
- R2: While reset-request (bit 0) is 0, a write at the register offset loads bits 7,6,4,3,2,1,0 from `cpu_wdata`. Bit 5 always reads 0.
- R3: While reset-request is 1, a write at the register offset changes only bit 0. Bits 7..1 keep their values.
- R4: A `core_rr_set` strobe makes bit 0 read 1 after the next clock edge, even if a CPU write clears bit 0 in the same cycle. The write lock is decided by the value of bit 0 before that edge.
- R5: `buf_unmap` follows bit 7 (test mode), and `resync_both` follows bit 6 (speed).
- R6: `resync_edge` pulses for one cycle, one cycle after `bus_rx` goes from 1 (recessive) to 0 (dominant). When bit 6 is 1, it also pulses after a change from 0 to 1.
- R7: With bit 4 (overrun enable) set, `ev_overrun` sets pending source 3.
- R8: With bit 3 (error enable) set, `ev_err_change` sets pending source 2.
- R9: With bit 2 (transmit enable) set, either `ev_tx_done` or `ev_tx_freed` sets pending source 1.
- R10: With bit 1 (receive enable) set, `ev_rx_avail` sets pending source 0.
- R11: An event whose enable is 0 is ignored. A pending source holds until its `irq_ack` bit (bit i for source i) is pulsed. An event arriving in the same cycle as its acknowledge keeps the source pending. `irq` is the OR of the pending sources and appears one cycle after the event.
- R12: A write at any other offset leaves the register unchanged. A read at any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 8 | CPU byte offset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register value when the offset matches, else 0 |
| core_rr_set | input | 1 | Protocol core forces reset-request to 1 |
| ev_overrun | input | 1 | Overrun status became set |
| ev_err_change | input | 1 | Error or bus status bits changed |
| ev_tx_done | input | 1 | Message transmitted successfully |
| ev_tx_freed | input | 1 | Transmit buffer accessible again after abort |
| ev_rx_avail | input | 1 | Received message available |
| irq_ack | input | 4 | Per-source acknowledge: 0 rx, 1 tx, 2 error, 3 overrun |
| irq | output | 1 | Interrupt request |
| reset_req | output | 1 | Reset-request bit to the core |
| buf_unmap | output | 1 | Message buffers removed from CPU map |
| resync_both | output | 1 | Speed bit: both edge directions resynchronize |
| bus_rx | input | 1 | Sampled bus line, 1 recessive |
| resync_edge | output | 1 | Resynchronization edge pulse |

## Verification
The hardest case to reach is a protocol-core strobe that lands in the same cycle as a CPU write clearing reset-request. In that cycle the lock has to follow the old value of bit 0, while the new value of bit 0 has to follow the core. The bench first unlocks the register. It then pulses `core_rr_set` in the same cycle as a write that both changes the enables and clears bit 0, and reads the result back. The same-cycle event-and-acknowledge collision is reached in a similar way: the event and the acknowledge are raised on the same falling edge.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned N_SRC = 4;

  localparam int unsigned SRC_RX  = 0;
  localparam int unsigned SRC_TX  = 1;
  localparam int unsigned SRC_ERR = 2;
  localparam int unsigned SRC_OVR = 3;

  typedef struct packed {
    logic mode;
    logic spd;
    logic rsvd;
    logic oie;
    logic eie;
    logic tie;
    logic rie;
    logic rr;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{mode: 1'b0, spd: 1'b0, rsvd: 1'b0, oie: 1'b0,
                                 eie: 1'b0, tie: 1'b0, rie: 1'b0, rr: 1'b1};
endpackage

// File: rtl/can_ctrl_regfile.sv
module can_ctrl_regfile
  import can_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             core_rr_set,
  output ctl_t             ctl_q
);
  ctl_t wr_val;
  ctl_t ctl_d;

  always_comb begin
    wr_val      = ctl_t'(wdata);
    wr_val.rsvd = 1'b0;
    ctl_d       = ctl_q;
    if (wr_hit) begin
      if (ctl_q.rr) ctl_d.rr = wdata[0];
      else          ctl_d    = wr_val;
    end
    if (core_rr_set) ctl_d.rr = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/can_ctrl_irq.sv
module can_ctrl_irq
  import can_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] ack,
  output logic             irq
);
  logic [N_SRC-1:0] pend_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= (pend_q[i] & ~ack[i]) | (ev[i] & en[i]);
    end
  end

  assign irq = |pend_q;
endmodule

// File: rtl/can_ctrl_resync.sv
module can_ctrl_resync (
  input  logic clk,
  input  logic rst_n,
  input  logic both_edges,
  input  logic bus_rx,
  output logic edge_q
);
  logic prev_q;
  logic fall, rise;

  assign fall = prev_q & ~bus_rx;
  assign rise = ~prev_q & bus_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      edge_q <= 1'b0;
    end else begin
      prev_q <= bus_rx;
      edge_q <= fall | (both_edges & rise);
    end
  end
endmodule

// File: rtl/can_ctrl_reg.sv
module can_ctrl_reg
  import can_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              core_rr_set,
  input  logic              ev_overrun,
  input  logic              ev_err_change,
  input  logic              ev_tx_done,
  input  logic              ev_tx_freed,
  input  logic              ev_rx_avail,
  input  logic [N_SRC-1:0]  irq_ack,
  output logic              irq,
  output logic              reset_req,
  output logic              buf_unmap,
  output logic              resync_both,
  input  logic              bus_rx,
  output logic              resync_edge
);
  ctl_t             reg_q;
  logic             addr_hit;
  logic [N_SRC-1:0] ev_vec;
  logic [N_SRC-1:0] en_vec;

  assign addr_hit = (cpu_addr == REG_ADDR);

  can_ctrl_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit      (cpu_wr & addr_hit),
    .wdata       (cpu_wdata),
    .core_rr_set (core_rr_set),
    .ctl_q       (reg_q)
  );

  always_comb begin
    ev_vec          = '0;
    en_vec          = '0;
    ev_vec[SRC_RX]  = ev_rx_avail;
    ev_vec[SRC_TX]  = ev_tx_done | ev_tx_freed;
    ev_vec[SRC_ERR] = ev_err_change;
    ev_vec[SRC_OVR] = ev_overrun;
    en_vec[SRC_RX]  = reg_q.rie;
    en_vec[SRC_TX]  = reg_q.tie;
    en_vec[SRC_ERR] = reg_q.eie;
    en_vec[SRC_OVR] = reg_q.oie;
  end

  can_ctrl_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev_vec),
    .en    (en_vec),
    .ack   (irq_ack),
    .irq   (irq)
  );

  can_ctrl_resync u_resync (
    .clk        (clk),
    .rst_n      (rst_n),
    .both_edges (reg_q.spd),
    .bus_rx     (bus_rx),
    .edge_q     (resync_edge)
  );

  assign cpu_rdata   = addr_hit ? REG_W'(reg_q) : '0;
  assign reset_req   = reg_q.rr;
  assign buf_unmap   = reg_q.mode;
  assign resync_both = reg_q.spd;
endmodule

// File: rtl/can_ctrl_reg_chk.sv
module can_ctrl_reg_chk
  import can_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              core_rr_set,
  input logic              ev_overrun,
  input logic              ev_err_change,
  input logic              ev_tx_done,
  input logic              ev_tx_freed,
  input logic              ev_rx_avail,
  input logic              irq,
  input logic              bus_rx,
  input logic              resync_edge,
  input ctl_t              reg_q
);
  p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q.rr && cpu_wr && cpu_addr == REG_ADDR) |=> $stable(reg_q[7:1]));

  p_core_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_rr_set |=> reg_q.rr);

  p_ovr_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_overrun && reg_q.oie) |=> irq);

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !ev_overrun && !ev_err_change && !ev_tx_done && !ev_tx_freed && !ev_rx_avail) |=> !irq);

  p_fast_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_edge && !$past(reg_q.spd)) |-> !$past(bus_rx));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_q.rsvd);
endmodule

bind can_ctrl_reg can_ctrl_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_addr      (cpu_addr),
  .cpu_wr        (cpu_wr),
  .core_rr_set   (core_rr_set),
  .ev_overrun    (ev_overrun),
  .ev_err_change (ev_err_change),
  .ev_tx_done    (ev_tx_done),
  .ev_tx_freed   (ev_tx_freed),
  .ev_rx_avail   (ev_rx_avail),
  .irq           (irq),
  .bus_rx        (bus_rx),
  .resync_edge   (resync_edge),
  .reg_q         (reg_q)
);

// File: tb/can_ctrl_reg_tb.sv
module can_ctrl_reg_tb;
  localparam logic [7:0] RA = 8'h20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cpu_addr = RA;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       core_rr_set = 1'b0;
  logic       ev_overrun = 1'b0, ev_err_change = 1'b0, ev_tx_done = 1'b0;
  logic       ev_tx_freed = 1'b0, ev_rx_avail = 1'b0;
  logic [3:0] irq_ack = '0;
  logic       irq, reset_req, buf_unmap, resync_both, resync_edge;
  logic       bus_rx = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  can_ctrl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .core_rr_set(core_rr_set),
    .ev_overrun(ev_overrun), .ev_err_change(ev_err_change),
    .ev_tx_done(ev_tx_done), .ev_tx_freed(ev_tx_freed),
    .ev_rx_avail(ev_rx_avail), .irq_ack(irq_ack), .irq(irq),
    .reset_req(reset_req), .buf_unmap(buf_unmap), .resync_both(resync_both),
    .bus_rx(bus_rx), .resync_edge(resync_edge)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    cyc();
    cpu_wr = 1'b0; cpu_addr = RA;
  endtask

  task automatic rd_check(input string req, input logic [7:0] exp);
    cpu_addr = RA;
    #1;
    check(req, cpu_rdata, exp);
  endtask

  task automatic ack(input logic [3:0] m);
    irq_ack = m;
    cyc();
    irq_ack = '0;
  endtask

  task automatic t_reset();
    rd_check("R1 reset value", 8'h01);
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 unmap", {7'd0, buf_unmap}, 8'd0);
    check("R1 resync", {7'd0, resync_edge}, 8'd0);
  endtask

  task automatic t_unlocked();
    wr(RA, 8'h00);
    rd_check("R2 clear", 8'h00);
    wr(RA, 8'hFE);
    rd_check("R2 load, bit5 zero", 8'hDE);
    check("R5 unmap", {7'd0, buf_unmap}, 8'd1);
    check("R5 speed", {7'd0, resync_both}, 8'd1);
    wr(RA, 8'h00);
    check("R5 unmap off", {7'd0, buf_unmap}, 8'd0);
  endtask

  task automatic t_locked();
    wr(RA, 8'h01);
    rd_check("R3 set rr", 8'h01);
    wr(RA, 8'hFF);
    rd_check("R3 locked bits", 8'h01);
    check("R3 reset_req", {7'd0, reset_req}, 8'd1);
    wr(RA, 8'hFE);
    rd_check("R3 only rr cleared", 8'h00);
  endtask

  task automatic t_core();
    wr(RA, 8'h1E);
    rd_check("R4 setup", 8'h1E);
    core_rr_set = 1'b1;
    wr(RA, 8'h1C);
    core_rr_set = 1'b0;
    rd_check("R4 core wins rr", 8'h1D);
    wr(RA, 8'h1C);
    rd_check("R4 rr cleared", 8'h1C);
  endtask

  task automatic t_irq();
    ev_rx_avail = 1'b1; cyc(); ev_rx_avail = 1'b0;
    check("R11 disabled rx ignored", {7'd0, irq}, 8'd0);
    ev_overrun = 1'b1; cyc(); ev_overrun = 1'b0;
    check("R7 overrun irq", {7'd0, irq}, 8'd1);
    ack(4'b0001);
    check("R11 wrong ack holds", {7'd0, irq}, 8'd1);
    ack(4'b1000);
    check("R11 ack clears", {7'd0, irq}, 8'd0);
    ev_err_change = 1'b1; cyc(); ev_err_change = 1'b0;
    check("R8 error irq", {7'd0, irq}, 8'd1);
    ack(4'b0100);
    ev_tx_done = 1'b1; cyc(); ev_tx_done = 1'b0;
    check("R9 tx done irq", {7'd0, irq}, 8'd1);
    ack(4'b0010);
    check("R9 cleared", {7'd0, irq}, 8'd0);
    ev_tx_freed = 1'b1; cyc(); ev_tx_freed = 1'b0;
    check("R9 tx freed irq", {7'd0, irq}, 8'd1);
    ack(4'b0010);
    wr(RA, 8'h02);
    ev_overrun = 1'b1; cyc(); ev_overrun = 1'b0;
    check("R11 disabled overrun ignored", {7'd0, irq}, 8'd0);
    ev_rx_avail = 1'b1; cyc(); ev_rx_avail = 1'b0;
    check("R10 rx irq", {7'd0, irq}, 8'd1);
    ev_rx_avail = 1'b1; irq_ack = 4'b0001; cyc(); ev_rx_avail = 1'b0; irq_ack = '0;
    check("R11 event beats ack", {7'd0, irq}, 8'd1);
    ack(4'b0001);
    check("R11 final clear", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_addr();
    wr(8'h21, 8'hFF);
    rd_check("R12 other offset write", 8'h02);
    cpu_addr = 8'h1F;
    #1;
    check("R12 other offset read", cpu_rdata, 8'h00);
    cpu_addr = RA;
  endtask

  task automatic t_resync();
    wr(RA, 8'h00);
    bus_rx = 1'b0; cyc();
    check("R6 fall edge", {7'd0, resync_edge}, 8'd1);
    cyc();
    check("R6 one cycle", {7'd0, resync_edge}, 8'd0);
    bus_rx = 1'b1; cyc();
    check("R6 rise ignored slow-off", {7'd0, resync_edge}, 8'd0);
    wr(RA, 8'h40);
    bus_rx = 1'b0; cyc();
    check("R6 fall with speed", {7'd0, resync_edge}, 8'd1);
    bus_rx = 1'b1; cyc();
    check("R6 rise with speed", {7'd0, resync_edge}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlocked();
    t_locked();
    t_core();
    t_irq();
    t_addr();
    t_resync();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule